// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block stands in for the status-read path of a byte-wide flash device while an internal program or erase operation is running. A command strobe marks the end of a command sequence. It carries an operation code, a target address, a data byte and a random fault flag. From the cycle after the strobe, every read strobe returns a status byte instead of array contents. When the operation ends, reads return array contents again.

Bit 7 of the status byte is the polling bit. Bit 5 is the time-limit flag. All other status bits read 0. A per-operation cycle counter models how long the internal algorithm runs. Protected targets produce a busy window of fixed length and leave the data alone.

The cell array itself is not modelled. Reads outside status mode return one of three values:
- the most recently programmed byte, at its own address;
- `8'hFF` inside sectors that an erase has cleared;
- otherwise the `arr_data` input.

The address splits into sectors on its top `SW` bits.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `rd_data` is `8'h00`, no operation is active, and a read returns `arr_data`.
- R2: A program command (`op`=2'b01) is accepted on a `cmd_done` cycle. For the next `PROG_CYC` clock edges a read returns `{~d[7],1'b0,tmo,5'b0}`, where d is the programmed byte.
- R3: Once programming ends, a read at the programmed address returns the programmed byte. A read at any other address returns array data.
- R4: A sector erase (`op`=2'b10, sector taken from `cmd_addr[AW-1 -: SW]`) or a chip erase (`op`=2'b11) reads `8'h00` at any address while it runs for `ERASE_CYC` counting edges.
- R5: After an erase completes, reads inside the erased sectors return `8'hFF`. Sectors outside the erase keep their previous contents.
- R6: While `susp_req` is high during an unprotected erase, the erase counter is frozen. Reads inside the erasing sectors return `8'h80`, and reads elsewhere return array data.
- R7: A program command is accepted while an erase is suspended. Its status follows R2 and R3. The erase resumes only after `susp_req` falls and then completes.
- R8: A program to a protected sector (`prot_map` bit of its sector is 1) keeps the inverted polling bit for `2*CLK_MHZ` edges. After that, reads return array data and the byte is not stored.
- R9: An erase whose selected sectors are all protected reads `8'h00` for `100*CLK_MHZ` edges and then returns to array data with nothing erased.
- R10: A chip erase with some sectors protected erases only the unprotected ones.
- R11: If `fault_inj` is high with an accepted unprotected command, then on reaching its limit:
  - the operation sets bit 5;
  - bit 7 keeps its in-progress value;
  - the operation stays in status mode until reset.
- R12: A command arriving while a program runs is ignored. A command arriving while a non-suspended erase runs is also ignored.
- R13: Without `rd_en`, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_done | input | 1 | final write strobe of a command sequence |
| op | input | 2 | 01 program, 10 sector erase, 11 chip erase |
| cmd_addr | input | AW | target address (sector in top SW bits) |
| cmd_data | input | 8 | byte to program |
| prot_map | input | 2**SW | per-sector protection flags |
| susp_req | input | 1 | erase suspend request (level) |
| fault_inj | input | 1 | forces the accepted operation past its limit |
| rd_en | input | 1 | read strobe |
| rd_addr | input | AW | read address |
| arr_data | input | 8 | array contents for plain reads |
| rd_data | output | 8 | registered read result |

## Verification
The bench checks the last status read and the first data read exactly at the end of a program. A counter that is off by one in either direction shows up there as data one cycle early or status one cycle late.

Suspend is held for longer than a full erase and then released. An erase that keeps counting while suspended has already finished by then and returns `8'hFF` where status is expected. Protected targets are checked after their windows for unchanged data, which catches a design that writes through protection.

Fault runs are checked twice, with an ignored command in between. A time-limit flag that clears itself, or a stuck operation that accepts new commands, fails the second check.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int AW        = 8,
  parameter int SW        = 2,
  parameter int CLK_MHZ   = 2,
  parameter int PROG_CYC  = 10,
  parameter int ERASE_CYC = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_done,
  input  logic [1:0]        op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [(1<<SW)-1:0] prot_map,
  input  logic              susp_req,
  input  logic              fault_inj,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [7:0]        arr_data,
  output logic [7:0]        rd_data
);
  localparam int NS   = 1 << SW;
  localparam int PP   = 2 * CLK_MHZ;
  localparam int PE   = 100 * CLK_MHZ;
  localparam int M1   = (PROG_CYC > PP) ? PROG_CYC : PP;
  localparam int M2   = (ERASE_CYC > PE) ? ERASE_CYC : PE;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  logic          pact, pprot, pflt;
  logic [CW-1:0] pcnt;
  logic [AW-1:0] pa;
  logic [7:0]    pdat;
  logic          eact, eprot, eflt;
  logic [CW-1:0] ecnt;
  logic [NS-1:0] esel, rer;
  logic          tmo;
  logic          rp_v;
  logic [AW-1:0] rp_a;
  logic [7:0]    rp_d;
  logic [7:0]    stat;

  wire [SW-1:0] csec = cmd_addr[AW-1 -: SW];
  wire [SW-1:0] rsec = rd_addr[AW-1 -: SW];
  wire [SW-1:0] psec = rp_a[AW-1 -: SW];

  wire esusp = eact && !eprot && (susp_req || pact);
  wire erun  = eact && !esusp;
  wire pgo   = cmd_done && (op == 2'b01) && !pact && (!eact || esusp);
  wire ego   = cmd_done && op[1] && !pact && !eact;

  wire [NS-1:0] sel_n   = op[0] ? {NS{1'b1}} : (NS'(1) << csec);
  wire [NS-1:0] sel_up  = sel_n & ~prot_map;
  wire          all_prt = (sel_up == '0);

  wire [CW-1:0] plim = pprot ? CW'(PP - 1) : CW'(PROG_CYC - 1);
  wire [CW-1:0] elim = eprot ? CW'(PE - 1) : CW'(ERASE_CYC - 1);
  wire pend = pact && (pcnt == plim);
  wire eend = erun && (ecnt == elim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pact <= 1'b0; pprot <= 1'b0; pflt <= 1'b0; pcnt <= '0;
      pa <= '0; pdat <= '0;
      eact <= 1'b0; eprot <= 1'b0; eflt <= 1'b0; ecnt <= '0;
      esel <= '0; rer <= '0; tmo <= 1'b0;
      rp_v <= 1'b0; rp_a <= '0; rp_d <= '0;
    end else begin
      if (pgo) begin
        pact  <= 1'b1;
        pcnt  <= '0;
        pa    <= cmd_addr;
        pdat  <= cmd_data;
        pprot <= prot_map[csec];
        pflt  <= fault_inj && !prot_map[csec];
      end else if (pact) begin
        if (pend) begin
          if (pflt) tmo <= 1'b1;
          else begin
            pact <= 1'b0;
            if (!pprot) begin
              rp_v <= 1'b1;
              rp_a <= pa;
              rp_d <= pdat;
            end
          end
        end else pcnt <= pcnt + 1'b1;
      end

      if (ego) begin
        eact  <= 1'b1;
        ecnt  <= '0;
        esel  <= sel_up;
        eprot <= all_prt;
        eflt  <= fault_inj && !all_prt;
      end else if (erun) begin
        if (eend) begin
          if (eflt) tmo <= 1'b1;
          else begin
            eact <= 1'b0;
            if (!eprot) begin
              rer <= rer | esel;
              if (esel[psec]) rp_v <= 1'b0;
            end
          end
        end else ecnt <= ecnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (pact)                                    stat = {~pdat[7], 1'b0, tmo, 5'b0};
    else if (erun)                               stat = {2'b00, tmo, 5'b0};
    else if (esusp && esel[rsec])                stat = 8'h80;
    else if (rp_v && rp_a == rd_addr)            stat = rp_d;
    else if (rer[rsec])                          stat = 8'hFF;
    else                                         stat = arr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= stat;
  end
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       pact,
  input logic       eact,
  input logic       esusp,
  input logic       pd7,
  input logic       tmo
);
  a_r2_prog_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (pact && rd_en) |=> (rd_data[7] == ~$past(pd7)));
  a_r4_erase_low: assert property (@(posedge clk) disable iff (!rst_n)
    (eact && !esusp && !pact && rd_en) |=> !rd_data[7]);
  a_r6_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    esusp |=> eact);
  a_r11_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> tmo);
  a_r11_tmo_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (pact || eact));
  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pact |-> (!eact || esusp));
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind flash_status_gen flash_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
  .pact(pact), .eact(eact), .esusp(esusp), .pd7(pdat[7]), .tmo(tmo)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  localparam int CLK_P = 10;
  localparam int PROG  = 10;
  localparam int ER    = 30;
  localparam int PP    = 4;
  localparam int PE    = 200;

  logic clk = 0, rst_n = 0, cmd_done = 0, susp_req = 0, fault_inj = 0, rd_en = 0;
  logic [1:0] op = 0;
  logic [7:0] cmd_addr = 0, cmd_data = 0, rd_addr = 0, arr_data = 8'h5A, rd_data;
  logic [3:0] prot_map = 0;
  int tests = 0, fails = 0;
  logic [7:0] g;

  always #(CLK_P/2) clk = ~clk;

  flash_status_gen #(.AW(8), .SW(2), .CLK_MHZ(2), .PROG_CYC(PROG), .ERASE_CYC(ER)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .op(op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .prot_map(prot_map), .susp_req(susp_req), .fault_inj(fault_inj),
    .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data));

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; susp_req = 0; prot_map = 0; cmd_done = 0; rd_en = 0;
    repeat (2) tick;
    rst_n = 1;
    tick;
  endtask

  task automatic cmd(logic [1:0] o, logic [7:0] a, logic [7:0] d, logic f);
    cmd_done = 1; op = o; cmd_addr = a; cmd_data = d; fault_inj = f;
    tick;
    cmd_done = 0; fault_inj = 0; op = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    rd_en = 1; rd_addr = a;
    tick;
    rd_en = 0; v = rd_data;
  endtask

  task automatic t_reset;
    do_reset;
    chk("R1 reset value", rd_data, 8'h00);
    rd(8'h33, g); chk("R1 idle read", g, 8'h5A);
  endtask

  task automatic t_program;
    cmd(2'b01, 8'h45, 8'h3C, 0);
    rd(8'h45, g); chk("R2 early status", g, 8'h80);
    repeat (PROG - 2) tick;
    rd(8'h45, g); chk("R2 last status", g, 8'h80);
    rd(8'h45, g); chk("R3 first data", g, 8'h3C);
    rd(8'h46, g); chk("R3 other addr", g, 8'h5A);
    cmd(2'b01, 8'h10, 8'hA5, 0);
    rd(8'h10, g); chk("R2 status bit7 clear", g, 8'h00);
    repeat (PROG) tick;
    rd(8'h10, g); chk("R3 data", g, 8'hA5);
    rd(8'h10, g);
    arr_data = 8'h11;
    repeat (3) tick;
    chk("R13 hold", rd_data, 8'hA5);
    arr_data = 8'h5A;
  endtask

  task automatic t_erase;
    cmd(2'b10, 8'h80, 8'h00, 0);
    rd(8'h05, g); chk("R4 erase status", g, 8'h00);
    repeat (ER - 2) tick;
    rd(8'h05, g); chk("R4 last status", g, 8'h00);
    rd(8'h85, g); chk("R5 erased", g, 8'hFF);
    rd(8'h05, g); chk("R5 other sector", g, 8'h5A);
    rd(8'h10, g); chk("R5 program kept", g, 8'hA5);
  endtask

  task automatic t_busy;
    cmd(2'b01, 8'h20, 8'h00, 0);
    cmd(2'b10, 8'hC0, 8'h00, 0);
    repeat (ER + 2) tick;
    rd(8'hC0, g); chk("R12 erase during program ignored", g, 8'h5A);
    rd(8'h20, g); chk("R12 program done", g, 8'h00);
    cmd(2'b10, 8'hC0, 8'h00, 0);
    cmd(2'b01, 8'h30, 8'h77, 0);
    repeat (ER + 2) tick;
    rd(8'h30, g); chk("R12 program during erase ignored", g, 8'h5A);
    rd(8'hC5, g); chk("R12 erase ran", g, 8'hFF);
  endtask

  task automatic t_suspend;
    do_reset;
    cmd(2'b10, 8'h40, 8'h00, 0);
    repeat (5) tick;
    susp_req = 1;
    rd(8'h41, g); chk("R6 suspended region", g, 8'h80);
    rd(8'h01, g); chk("R6 outside region", g, 8'h5A);
    cmd(2'b01, 8'h02, 8'h7E, 0);
    rd(8'h02, g); chk("R7 program status", g, 8'h80);
    repeat (PROG) tick;
    rd(8'h02, g); chk("R7 program data", g, 8'h7E);
    rd(8'h41, g); chk("R7 erase still suspended", g, 8'h80);
    repeat (ER) tick;
    susp_req = 0;
    rd(8'h41, g); chk("R6 frozen counter", g, 8'h00);
    repeat (ER) tick;
    rd(8'h41, g); chk("R7 erase resumed", g, 8'hFF);
    rd(8'h02, g); chk("R7 program kept", g, 8'h7E);
  endtask

  task automatic t_protect;
    do_reset;
    prot_map = 4'b0010;
    cmd(2'b01, 8'h50, 8'h00, 0);
    repeat (PP - 1) tick;
    rd(8'h50, g); chk("R8 window", g, 8'h80);
    rd(8'h50, g); chk("R8 unchanged", g, 8'h5A);
    cmd(2'b10, 8'h50, 8'h00, 0);
    repeat (PE - 1) tick;
    rd(8'h50, g); chk("R9 window", g, 8'h00);
    rd(8'h50, g); chk("R9 unchanged", g, 8'h5A);
    cmd(2'b11, 8'h00, 8'h00, 0);
    repeat (ER + 2) tick;
    rd(8'h05, g); chk("R10 unprot erased", g, 8'hFF);
    rd(8'h50, g); chk("R10 prot kept", g, 8'h5A);
    rd(8'hC0, g); chk("R10 unprot erased hi", g, 8'hFF);
  endtask

  task automatic t_fault;
    do_reset;
    cmd(2'b01, 8'h11, 8'h80, 1);
    repeat (PROG + 3) tick;
    rd(8'h11, g); chk("R11 program timeout", g, 8'h20);
    cmd(2'b10, 8'h00, 8'h00, 0);
    repeat (ER + 3) tick;
    rd(8'h11, g); chk("R11 stays stuck", g, 8'h20);
    do_reset;
    cmd(2'b10, 8'h00, 8'h00, 1);
    repeat (ER + 3) tick;
    rd(8'h05, g); chk("R11 erase timeout", g, 8'h20);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired (R1..R13 incomplete)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_program;
    t_erase;
    t_busy;
    t_suspend;
    t_protect;
    t_fault;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule